// File: doc/BRIEF.md
# Exclusive Two-Level Cache Victim Controller

This controller runs the line movements that keep a first-level cache and a second-level cache exclusive, so that any line sits in at most one of them. It takes one first-level miss at a time. The miss is served from one of three places, checked in this order: a small victim buffer of dirty lines waiting to be written to memory, the second-level cache, or memory. Whichever source supplies the line gives it up. The line is installed only in the first level.

Installing the line displaces a first-level line, and that line moves down into the second level. That move may in turn push a line out of the second level. A dirty pushed line is queued in the victim buffer, which drains to memory through its own ready/valid port. A clean pushed line is dropped. Each step of the sequence talks to its neighbour through a ready/valid pair. The neighbour's response fields are sampled in the cycle the handshake completes. Tag lookup and data movement belong to the neighbours.

Top module: `xvc_excl_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, and `l2q_valid`, `mem_valid`, `l1f_valid`, `l2w_valid`, `wb_valid` and `done_valid` are all 0.
- R2: A miss whose address matches a line held in the victim buffer is served from that entry. No second-level lookup and no memory fetch are issued. The fill carries `l1f_dirty`=1, `done_src` is 0, and the entry is removed so it never appears on the drain port.
- R3: On a victim-buffer miss, a second-level take request is issued for the miss address. If `l2q_hit`=1, the second level gives up the line, no memory fetch follows, the fill carries the returned `l2q_dirty`, and `done_src` is 1.
- R4: If the take request returns `l2q_hit`=0, a memory fetch for the miss address follows. The fill carries `l1f_dirty`=0, and `done_src` is 2.
- R5: The line being filled is never written into the second level. Only the displaced first-level line travels down on `l2w`.
- R6: A displaced first-level line reported with `l1f_vic_valid`=1 is written into the second level with its own address and dirty bit. With `l1f_vic_valid`=0 no second-level write is issued.
- R7: A second-level eviction reported with `l2w_ev_valid`=1 and `l2w_ev_dirty`=1 enters the victim buffer and later leaves on the drain port. A clean eviction is dropped.
- R8: The victim buffer drains in the order lines entered it, skipping removed entries. Draining pauses while a miss is being compared against the buffer.
- R9: The victim buffer holds VB_DEPTH (default 4) entries. Slots are counted from the oldest undrained entry to the newest. `miss_ready` stays 0 while all slots are taken, and no entry is ever written into a full buffer.
- R10: `done_valid` stays 1 until `done_ready` is seen. No new miss is accepted before then.
- R11: At most one step handshake is offered at a time. `miss_ready` is 1 only when no step is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | First-level miss request |
| miss_ready | output | 1 | Controller accepts a miss |
| miss_addr | input | AW | Line address of the miss |
| l2q_valid | output | 1 | Second-level take request |
| l2q_ready | input | 1 | Second level answers the take |
| l2q_addr | output | AW | Address looked up and taken |
| l2q_hit | input | 1 | Line was present and is now removed |
| l2q_dirty | input | 1 | Dirty bit of the taken line |
| mem_valid | output | 1 | Memory fetch request |
| mem_ready | input | 1 | Memory delivers the line |
| mem_addr | output | AW | Address fetched |
| l1f_valid | output | 1 | First-level install request |
| l1f_ready | input | 1 | First level installs the line |
| l1f_addr | output | AW | Address installed |
| l1f_dirty | output | 1 | Dirty bit installed with the line |
| l1f_vic_valid | input | 1 | A line was displaced by the install |
| l1f_vic_addr | input | AW | Displaced line address |
| l1f_vic_dirty | input | 1 | Displaced line dirty bit |
| l2w_valid | output | 1 | Second-level install of the displaced line |
| l2w_ready | input | 1 | Second level installs it |
| l2w_addr | output | AW | Address moved down |
| l2w_dirty | output | 1 | Dirty bit moved down |
| l2w_ev_valid | input | 1 | A second-level line was pushed out |
| l2w_ev_addr | input | AW | Pushed-out line address |
| l2w_ev_dirty | input | 1 | Pushed-out line dirty bit |
| wb_valid | output | 1 | Victim buffer offers a line to memory |
| wb_ready | input | 1 | Memory accepts the line |
| wb_addr | output | AW | Address written back |
| done_valid | output | 1 | Miss sequence complete |
| done_ready | input | 1 | Completion acknowledged |
| done_src | output | 2 | Supplier: 0 buffer, 1 second level, 2 memory |

## Verification
Some rules hold on every cycle regardless of what the neighbours answer, and the assertions check these: only one step is offered at a time, the filled line is never written downward, no push lands in a full buffer, and draining pauses during a buffer compare. The same goes for `done_valid` staying up until acknowledged, and for a memory fetch never starting without a second-level miss before it. Other behaviour depends on the data the neighbours return, and only the directed scenarios show it. These scenarios check which source supplies each miss and the dirty bit installed with the line. They also check that a clean eviction is dropped, the exact order of drained addresses with a removed entry skipped, and that `miss_ready` goes low once the buffer fills and recovers after it drains.

// File: rtl/xvc_pkg.sv
package xvc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_L2_TAKE,
        ST_MEM_GET,
        ST_FILL_L1,
        ST_MOVE_VICTIM_L2,
        ST_EVICT_L2,
        ST_DONE
    } xvc_state_e;

    typedef enum logic [1:0] {
        SRC_VBUF = 2'd0,
        SRC_L2   = 2'd1,
        SRC_MEM  = 2'd2
    } xvc_src_e;

    typedef struct packed {
        logic vld;
        logic dirty;
    } xvc_meta_t;

    // Lines supplied by the victim buffer are always dirty; memory lines are clean.
    function automatic logic fill_dirty_of(xvc_src_e src, logic l2_dirty);
        case (src)
            SRC_VBUF: return 1'b1;
            SRC_L2:   return l2_dirty;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic needs_writeback(xvc_meta_t m);
        return m.vld && m.dirty;
    endfunction

endpackage

// File: rtl/xvc_vbuf.sv
module xvc_vbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 34
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          lk_en,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    input  logic          hold,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    input  logic          wb_ready,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW:0]       wr_q, rd_q, occ;
    logic [PW-1:0]     widx, head;
    logic [AW-1:0]     addr_q [DEPTH];
    logic [DEPTH-1:0]  v_q, v_nxt, hit_vec;
    logic              pop;

    assign occ  = wr_q - rd_q;
    assign widx = wr_q[PW-1:0];
    assign head = rd_q[PW-1:0];
    assign full = (occ == (PW+1)'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = v_q[i] && (addr_q[i] == lk_addr);
    end
    assign lk_hit = |hit_vec;

    assign wb_valid = (occ != '0) && v_q[head] && !hold;
    assign wb_addr  = addr_q[head];
    // Removed entries (holes) retire without a write-back.
    assign pop      = (occ != '0) && (!v_q[head] || (wb_valid && wb_ready));

    always_comb begin
        v_nxt = v_q;
        if (lk_en) v_nxt = v_nxt & ~hit_vec;
        if (pop)   v_nxt[head] = 1'b0;
        if (push)  v_nxt[widx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
            v_q  <= '0;
        end else begin
            v_q <= v_nxt;
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) addr_q[widx] <= push_addr;
    end

    p_no_push_full_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_occ_bound_r9: assert property (@(posedge clk) disable iff (rst)
        occ <= (PW+1)'(DEPTH));
    p_hold_drain_r8: assert property (@(posedge clk) disable iff (rst)
        hold |-> !wb_valid);
    p_single_copy_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
    p_drain_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (hold || (wb_valid && $stable(wb_addr))));

endmodule

// File: rtl/xvc_seq.sv
module xvc_seq
    import xvc_pkg::*;
#(
    parameter int AW = 34
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_valid,
    output logic          miss_ready,
    input  logic [AW-1:0] miss_addr,
    input  logic          vb_full,
    output logic          vb_lk_en,
    output logic [AW-1:0] vb_lk_addr,
    input  logic          vb_hit,
    output logic          vb_hold,
    output logic          vb_push,
    output logic [AW-1:0] vb_push_addr,
    output logic          l2q_valid,
    input  logic          l2q_ready,
    output logic [AW-1:0] l2q_addr,
    input  logic          l2q_hit,
    input  logic          l2q_dirty,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic          l1f_valid,
    input  logic          l1f_ready,
    output logic [AW-1:0] l1f_addr,
    output logic          l1f_dirty,
    input  logic          l1f_vic_valid,
    input  logic [AW-1:0] l1f_vic_addr,
    input  logic          l1f_vic_dirty,
    output logic          l2w_valid,
    input  logic          l2w_ready,
    output logic [AW-1:0] l2w_addr,
    output logic          l2w_dirty,
    input  logic          l2w_ev_valid,
    input  logic [AW-1:0] l2w_ev_addr,
    input  logic          l2w_ev_dirty,
    output logic          done_valid,
    input  logic          done_ready,
    output logic [1:0]    done_src
);
    xvc_state_e    st_q, st_d;
    logic [AW-1:0] cur_q, vic_addr_q, ev_addr_q;
    xvc_meta_t     vic_q, ev_q;
    xvc_src_e      src_q;
    logic          fdirty_q;

    assign miss_ready   = (st_q == ST_IDLE) && !vb_full;
    assign vb_lk_en     = (st_q == ST_PROBE);
    assign vb_lk_addr   = cur_q;
    assign vb_hold      = (st_q == ST_PROBE);
    assign vb_push      = (st_q == ST_EVICT_L2);
    assign vb_push_addr = ev_addr_q;
    assign l2q_valid    = (st_q == ST_L2_TAKE);
    assign l2q_addr     = cur_q;
    assign mem_valid    = (st_q == ST_MEM_GET);
    assign mem_addr     = cur_q;
    assign l1f_valid    = (st_q == ST_FILL_L1);
    assign l1f_addr     = cur_q;
    assign l1f_dirty    = fdirty_q;
    assign l2w_valid    = (st_q == ST_MOVE_VICTIM_L2);
    assign l2w_addr     = vic_addr_q;
    assign l2w_dirty    = vic_q.dirty;
    assign done_valid   = (st_q == ST_DONE);
    assign done_src     = src_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:           if (miss_valid && miss_ready) st_d = ST_PROBE;
            ST_PROBE:          st_d = vb_hit ? ST_FILL_L1 : ST_L2_TAKE;
            ST_L2_TAKE:        if (l2q_ready) st_d = l2q_hit ? ST_FILL_L1 : ST_MEM_GET;
            ST_MEM_GET:        if (mem_ready) st_d = ST_FILL_L1;
            ST_FILL_L1:        if (l1f_ready) st_d = l1f_vic_valid ? ST_MOVE_VICTIM_L2 : ST_DONE;
            ST_MOVE_VICTIM_L2: if (l2w_ready)
                                   st_d = (l2w_ev_valid && l2w_ev_dirty) ? ST_EVICT_L2 : ST_DONE;
            ST_EVICT_L2:       st_d = ST_DONE;
            ST_DONE:           if (done_ready) st_d = ST_IDLE;
            default:           st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cur_q      <= '0;
            src_q      <= SRC_MEM;
            fdirty_q   <= 1'b0;
            vic_q      <= '0;
            ev_q       <= '0;
            vic_addr_q <= '0;
            ev_addr_q  <= '0;
        end else begin
            st_q <= st_d;
            case (st_q)
                ST_IDLE: if (miss_valid && miss_ready) cur_q <= miss_addr;
                ST_PROBE: if (vb_hit) begin
                    src_q    <= SRC_VBUF;
                    fdirty_q <= fill_dirty_of(SRC_VBUF, 1'b0);
                end
                ST_L2_TAKE: if (l2q_ready && l2q_hit) begin
                    src_q    <= SRC_L2;
                    fdirty_q <= fill_dirty_of(SRC_L2, l2q_dirty);
                end
                ST_MEM_GET: if (mem_ready) begin
                    src_q    <= SRC_MEM;
                    fdirty_q <= fill_dirty_of(SRC_MEM, 1'b0);
                end
                ST_FILL_L1: if (l1f_ready) begin
                    vic_q      <= '{vld: l1f_vic_valid, dirty: l1f_vic_dirty};
                    vic_addr_q <= l1f_vic_addr;
                end
                ST_MOVE_VICTIM_L2: if (l2w_ready) begin
                    ev_q      <= '{vld: l2w_ev_valid, dirty: l2w_ev_dirty};
                    ev_addr_q <= l2w_ev_addr;
                end
                default: ;
            endcase
        end
    end

    p_one_step_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l2q_valid, mem_valid, l1f_valid, l2w_valid, vb_push, done_valid}));
    p_idle_only_r11: assert property (@(posedge clk) disable iff (rst)
        miss_ready |-> !(l2q_valid || mem_valid || l1f_valid || l2w_valid || done_valid));
    p_no_fill_down_r5: assert property (@(posedge clk) disable iff (rst)
        l2w_valid |-> (l2w_addr != cur_q));
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_ready) |=> done_valid);
    p_mem_after_miss_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(l2q_valid && l2q_ready && !l2q_hit));
    p_push_dirty_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(vb_push) |-> $past(l2w_valid && l2w_ready && needs_writeback(
            '{vld: l2w_ev_valid, dirty: l2w_ev_dirty})));

endmodule

// File: rtl/xvc_excl_ctrl.sv
module xvc_excl_ctrl #(
    parameter int AW       = 34,
    parameter int VB_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_valid,
    output logic          miss_ready,
    input  logic [AW-1:0] miss_addr,
    output logic          l2q_valid,
    input  logic          l2q_ready,
    output logic [AW-1:0] l2q_addr,
    input  logic          l2q_hit,
    input  logic          l2q_dirty,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic          l1f_valid,
    input  logic          l1f_ready,
    output logic [AW-1:0] l1f_addr,
    output logic          l1f_dirty,
    input  logic          l1f_vic_valid,
    input  logic [AW-1:0] l1f_vic_addr,
    input  logic          l1f_vic_dirty,
    output logic          l2w_valid,
    input  logic          l2w_ready,
    output logic [AW-1:0] l2w_addr,
    output logic          l2w_dirty,
    input  logic          l2w_ev_valid,
    input  logic [AW-1:0] l2w_ev_addr,
    input  logic          l2w_ev_dirty,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic [AW-1:0] wb_addr,
    output logic          done_valid,
    input  logic          done_ready,
    output logic [1:0]    done_src
);
    logic          vb_full, vb_lk_en, vb_hit, vb_hold, vb_push;
    logic [AW-1:0] vb_lk_addr, vb_push_addr;

    xvc_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .vb_full(vb_full), .vb_lk_en(vb_lk_en), .vb_lk_addr(vb_lk_addr),
        .vb_hit(vb_hit), .vb_hold(vb_hold), .vb_push(vb_push), .vb_push_addr(vb_push_addr),
        .l2q_valid(l2q_valid), .l2q_ready(l2q_ready), .l2q_addr(l2q_addr),
        .l2q_hit(l2q_hit), .l2q_dirty(l2q_dirty),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .l1f_valid(l1f_valid), .l1f_ready(l1f_ready), .l1f_addr(l1f_addr),
        .l1f_dirty(l1f_dirty), .l1f_vic_valid(l1f_vic_valid),
        .l1f_vic_addr(l1f_vic_addr), .l1f_vic_dirty(l1f_vic_dirty),
        .l2w_valid(l2w_valid), .l2w_ready(l2w_ready), .l2w_addr(l2w_addr),
        .l2w_dirty(l2w_dirty), .l2w_ev_valid(l2w_ev_valid),
        .l2w_ev_addr(l2w_ev_addr), .l2w_ev_dirty(l2w_ev_dirty),
        .done_valid(done_valid), .done_ready(done_ready), .done_src(done_src)
    );

    xvc_vbuf #(.DEPTH(VB_DEPTH), .AW(AW)) u_vbuf (
        .clk(clk), .rst(rst),
        .push(vb_push), .push_addr(vb_push_addr),
        .lk_en(vb_lk_en), .lk_addr(vb_lk_addr), .lk_hit(vb_hit),
        .hold(vb_hold),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
        .full(vb_full)
    );

endmodule

// File: tb/sim_xvc_excl_ctrl.sv
module sim_xvc_excl_ctrl;
    localparam int AW = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic miss_valid = 0, miss_ready;
    logic [AW-1:0] miss_addr = '0;
    logic l2q_valid, l2q_ready = 0, l2q_hit = 0, l2q_dirty = 0;
    logic [AW-1:0] l2q_addr;
    logic mem_valid, mem_ready = 0;
    logic [AW-1:0] mem_addr;
    logic l1f_valid, l1f_ready = 0, l1f_dirty, l1f_vic_valid = 0, l1f_vic_dirty = 0;
    logic [AW-1:0] l1f_addr, l1f_vic_addr = '0;
    logic l2w_valid, l2w_ready = 0, l2w_dirty, l2w_ev_valid = 0, l2w_ev_dirty = 0;
    logic [AW-1:0] l2w_addr, l2w_ev_addr = '0;
    logic wb_valid, wb_ready = 0;
    logic [AW-1:0] wb_addr;
    logic done_valid, done_ready = 0;
    logic [1:0] done_src;

    xvc_excl_ctrl #(.AW(AW), .VB_DEPTH(4)) u0 (.*);

    int n_checks = 0, n_errors = 0;
    int n_mem = 0, n_l2q = 0, n_l2w = 0, n_drain = 0;
    logic [AW-1:0] drained [16];

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_valid && mem_ready) n_mem++;
            if (l2q_valid && l2q_ready) n_l2q++;
            if (l2w_valid && l2w_ready) n_l2w++;
            if (wb_valid && wb_ready) begin
                if (n_drain < 16) drained[n_drain] = wb_addr;
                n_drain++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One complete miss. src: 0 buffer, 1 second level, 2 memory.
    task automatic do_miss(input logic [AW-1:0] a, input int src, input bit l2d,
                           input bit vv, input logic [AW-1:0] va, input bit vd,
                           input bit ev, input logic [AW-1:0] ea, input bit ed,
                           input int dly);
        int mem0 = n_mem, l2q0 = n_l2q, l2w0 = n_l2w;
        bit exp_d;
        @(negedge clk);
        miss_valid = 1; miss_addr = a;
        while (!miss_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        miss_valid = 0;
        if (src != 0) begin
            while (!l2q_valid) @(negedge clk);
            chk(l2q_addr == a, "R3", "take address", 64'(l2q_addr), 64'(a));
            l2q_ready = 1; l2q_hit = (src == 1); l2q_dirty = l2d;
            @(posedge clk); @(negedge clk);
            l2q_ready = 0;
            if (src == 2) begin
                while (!mem_valid) @(negedge clk);
                chk(mem_addr == a, "R4", "fetch address", 64'(mem_addr), 64'(a));
                mem_ready = 1;
                @(posedge clk); @(negedge clk);
                mem_ready = 0;
            end
        end
        while (!l1f_valid) @(negedge clk);
        exp_d = (src == 0) ? 1'b1 : (src == 1) ? l2d : 1'b0;
        chk(l1f_addr == a, "R5", "fill address", 64'(l1f_addr), 64'(a));
        chk(l1f_dirty == exp_d, (src == 0) ? "R2" : (src == 1) ? "R3" : "R4",
            "fill dirty", 64'(l1f_dirty), 64'(exp_d));
        l1f_ready = 1; l1f_vic_valid = vv; l1f_vic_addr = va; l1f_vic_dirty = vd;
        @(posedge clk); @(negedge clk);
        l1f_ready = 0;
        if (vv) begin
            while (!l2w_valid) @(negedge clk);
            chk(l2w_addr == va, "R6", "move-down address", 64'(l2w_addr), 64'(va));
            chk(l2w_dirty == vd, "R6", "move-down dirty", 64'(l2w_dirty), 64'(vd));
            l2w_ready = 1; l2w_ev_valid = ev; l2w_ev_addr = ea; l2w_ev_dirty = ed;
            @(posedge clk); @(negedge clk);
            l2w_ready = 0;
        end
        while (!done_valid) @(negedge clk);
        chk(done_src == 2'(src), "R2", "done source", 64'(done_src), 64'(src));
        chk(miss_ready == 0, "R11", "miss_ready during sequence", 64'(miss_ready), 0);
        if (dly > 0) begin
            repeat (dly) @(negedge clk);
            chk(done_valid == 1, "R10", "done held", 64'(done_valid), 1);
            chk(miss_ready == 0, "R10", "no accept before ack", 64'(miss_ready), 0);
        end
        done_ready = 1;
        @(posedge clk); @(negedge clk);
        done_ready = 0;
        if (src == 0) begin
            chk(n_l2q == l2q0, "R2", "no take on buffer hit", 64'(n_l2q - l2q0), 0);
            chk(n_mem == mem0, "R2", "no fetch on buffer hit", 64'(n_mem - mem0), 0);
        end
        if (src == 1) chk(n_mem == mem0, "R3", "no fetch on take hit", 64'(n_mem - mem0), 0);
        if (src == 2) chk(n_mem == mem0 + 1, "R4", "one fetch", 64'(n_mem - mem0), 1);
        chk(n_l2w == l2w0 + (vv ? 1 : 0), "R6", "move-down count",
            64'(n_l2w - l2w0), 64'(vv ? 1 : 0));
    endtask

    task automatic t_reset();
        chk(miss_ready == 1, "R1", "miss_ready", 64'(miss_ready), 1);
        chk({l2q_valid, mem_valid, l1f_valid, l2w_valid, wb_valid, done_valid} == 0,
            "R1", "step valids", 64'({l2q_valid, mem_valid, l1f_valid, l2w_valid,
            wb_valid, done_valid}), 0);
    endtask

    task automatic t_mem_no_victim();   // R4, R6 (no victim)
        do_miss(34'h10, 2, 0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic t_l2_hit_clean_drop(); // R3, R5, R6, R7 (clean), R10
        do_miss(34'h20, 1, 1, 1, 34'h30, 0, 1, 34'h40, 0, 3);
        repeat (3) @(negedge clk);
        chk(wb_valid == 0, "R7", "clean eviction dropped", 64'(wb_valid), 0);
    endtask

    task automatic t_fill_buffer();     // R7 (dirty), R9
        do_miss(34'h50, 2, 0, 1, 34'h60, 1, 1, 34'h100, 1, 0);
        do_miss(34'h51, 1, 0, 1, 34'h61, 1, 1, 34'h101, 1, 0);
        do_miss(34'h52, 2, 0, 1, 34'h62, 0, 1, 34'h102, 1, 0);
        chk(wb_valid == 1 && wb_addr == 34'h100, "R7", "oldest dirty line offered",
            64'(wb_addr), 64'h100);
    endtask

    task automatic t_vbuf_hit();        // R2
        do_miss(34'h101, 0, 0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic t_full_stall();      // R9
        do_miss(34'h53, 2, 0, 1, 34'h63, 1, 1, 34'h103, 1, 0);
        @(negedge clk);
        chk(miss_ready == 0, "R9", "miss_ready low when full", 64'(miss_ready), 0);
        chk(n_drain == 0, "R7", "nothing drained yet", 64'(n_drain), 0);
    endtask

    task automatic t_drain();           // R8, R2, R9
        wb_ready = 1;
        repeat (12) @(negedge clk);
        wb_ready = 0;
        chk(n_drain == 3, "R8", "drained count", 64'(n_drain), 3);
        chk(drained[0] == 34'h100, "R8", "drain order 0", 64'(drained[0]), 64'h100);
        chk(drained[1] == 34'h102, "R2", "removed entry skipped", 64'(drained[1]), 64'h102);
        chk(drained[2] == 34'h103, "R8", "drain order 2", 64'(drained[2]), 64'h103);
        chk(miss_ready == 1, "R9", "miss_ready after drain", 64'(miss_ready), 1);
        chk(wb_valid == 0, "R8", "buffer empty", 64'(wb_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_mem_no_victim();
        t_l2_hit_clean_drop();
        t_fill_buffer();
        t_vbuf_hit();
        t_full_stall();
        t_drain();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule